// File: doc/BRIEF.md
# Interrupt Request and Enable Register Pair

This block keeps the interrupt state of a small handheld-console system bus. A five-bit request register collects single-cycle set pulses from the video unit (frame and status events), the timer, the serial port and the joypad. An eight-bit enable register holds the mask that the CPU programs. The block ANDs the two into a per-source pending vector for the CPU's dispatch logic.

The CPU sees both registers through a byte-wide port, and the block decodes its own two addresses. A CPU write to the request register and a hardware set pulse can land in the same clock cycle. When they do, the pulse wins for its own bit, so no event is lost. A write caused by a timer-register access or a video-control access can raise its request in that same cycle. That case is also covered, because the peripheral presents its pulse while the write is in progress.

Top module: `irq_flag_enable`

## Requirements
- R1: After a synchronous active-low reset, both registers hold zero: the request register reads 0xE0 and the enable register reads 0x00.
- R2: A read at address 0xFF0F returns the stored five request bits in bits 4..0, with bits 7..5 forced to one.
- R3: A CPU write at 0xFF0F stores only bits 4..0 of the write data, and the value is visible from the next cycle. Writing a zero clears a bit that no source is setting.
- R4: A CPU write at 0xFFFF stores all eight bits, and a read at 0xFFFF returns them unchanged.
- R5: Each source pulse sets a fixed request bit in the cycle after it is seen: frame bit 0, status bit 1, timer bit 2, serial bit 3, joypad bit 4. A set bit stays set until the CPU clears it.
- R6: When a set pulse and a CPU write to 0xFF0F occur in the same cycle, the pulsed bit ends up set. All other bits take the written value.
- R7: `pending[i]` equals request bit i AND enable bit i for i = 0..4. It follows the registers combinationally, with no added cycle.
- R8: A write to any other address changes neither register. A read of any other address returns 0xFF with `bus_hit` low, and `bus_hit` is high only for 0xFF0F and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU byte address |
| bus_wr | input | 1 | CPU write strobe for this cycle |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bus_hit | output | 1 | bus_addr selects one of the two registers |
| src_frame | input | 1 | Video frame event pulse (bit 0) |
| src_stat | input | 1 | Video status event pulse (bit 1) |
| src_timer | input | 1 | Timer overflow pulse (bit 2) |
| src_serial | input | 1 | Serial transfer done pulse (bit 3) |
| src_joypad | input | 1 | Joypad press pulse (bit 4) |
| pending | output | 5 | Request AND enable, per source |

## Verification
The bench drives a timer pulse and a joypad pulse in the same cycle as a CPU write of zero or of another pattern to the request register. A design that let the write win would silently drop those interrupts. It writes 0xFF to both registers: a request register that kept eight bits, or an enable register that dropped three, shows up at read-back. It also sets enable bits 7..5 with all requests raised, to catch a pending vector wired to the wrong bits. Writes and reads at neighbouring addresses (0xFF0E, 0xFFFE, 0xFF10) expose a loose address decoder, which would corrupt state or claim the bus.

// File: rtl/irq_regs_pkg.sv
// Package: shared widths, addresses and source bit positions for the
// interrupt request/enable register pair.
// Assumes a byte-wide data path and a 16-bit address space.
package irq_regs_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int NUM_SRC  = 5;

    localparam logic [ADDR_W-1:0] REQ_ADDR = 16'hFF0F;
    localparam logic [ADDR_W-1:0] EN_ADDR  = 16'hFFFF;

    // Fixed bit position of each hardware source in the request register.
    localparam int BIT_FRAME  = 0;
    localparam int BIT_STAT   = 1;
    localparam int BIT_TIMER  = 2;
    localparam int BIT_SERIAL = 3;
    localparam int BIT_JOYPAD = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_addr_dec.sv
// Address decoder: raises one select per register when the CPU address
// matches that register. Assumes the address is stable for the whole cycle.
module irq_addr_dec #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REQ_ADDR = 16'hFF0F,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 16'hFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_req,
    output logic              sel_en
);
    // Purpose: exact-match compare against each register address.
    always_comb begin
        sel_req = (addr == REQ_ADDR);
        sel_en  = (addr == EN_ADDR);
    end
endmodule

// File: rtl/irq_req_reg.sv
// Request register: stores one bit per interrupt source. A CPU write loads
// the low NUM_SRC data bits. A hardware set pulse forces its bit to one
// and wins over a write in the same cycle. Assumes single-cycle pulses.
module irq_req_reg #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] set_vec,
    output logic [NUM_SRC-1:0] q
);
    logic [NUM_SRC-1:0] base;

    // Purpose: choose the write value or the held value before the sets.
    always_comb begin
        base = wr_en ? wdata : q;
    end

    // Purpose: store the base value with the hardware sets ORed over it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= base | set_vec;
    end

    // R6 / R5: every bit pulsed in a cycle is set in the next one.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((q & $past(set_vec)) == $past(set_vec)));

    // R3: a write with no set pulse loads exactly the written bits.
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_vec == '0) |=> (q == $past(wdata)));

    // R8: with no write and no pulse the register holds.
    a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && set_vec == '0) |=> $stable(q));
endmodule

// File: rtl/irq_en_reg.sv
// Enable register: plain DATA_W-bit register loaded by a CPU write.
// Assumes wr_en is already qualified by the address decode.
module irq_en_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Purpose: load all bits on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end

    // R4: a write is stored in full.
    a_r4_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

    // R8: no write, no change.
    a_r8_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/irq_flag_enable.sv
// Top: interrupt request and enable registers with CPU byte access and a
// combined pending vector. Assumes source pulses are one cycle wide and
// synchronous to clk. Reads are combinational from address to data.
module irq_flag_enable
    import irq_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              src_frame,
    input  logic              src_stat,
    input  logic              src_timer,
    input  logic              src_serial,
    input  logic              src_joypad,
    output logic [NUM_SRC-1:0] pending
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic               sel_req;
    logic               sel_en;
    src_vec_t           set_vec;
    src_vec_t           req_q;
    logic [DATA_W-1:0]  en_q;
    logic [DATA_W-1:0]  req_view;

    irq_addr_dec #(
        .ADDR_W   (ADDR_W),
        .REQ_ADDR (REQ_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) u_dec (
        .addr    (bus_addr),
        .sel_req (sel_req),
        .sel_en  (sel_en)
    );

    // Purpose: place each source pulse at its fixed bit position.
    always_comb begin
        set_vec             = '0;
        set_vec[BIT_FRAME]  = src_frame;
        set_vec[BIT_STAT]   = src_stat;
        set_vec[BIT_TIMER]  = src_timer;
        set_vec[BIT_SERIAL] = src_serial;
        set_vec[BIT_JOYPAD] = src_joypad;
    end

    irq_req_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && sel_req),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .set_vec (set_vec),
        .q       (req_q)
    );

    irq_en_reg #(
        .DATA_W (DATA_W)
    ) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && sel_en),
        .wdata (bus_wdata),
        .q     (en_q)
    );

    // Purpose: pad the request register's unused upper bits with ones.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb req_view = {{PAD_W{1'b1}}, req_q};
        end else begin : g_nopad
            always_comb req_view = req_q[DATA_W-1:0];
        end
    endgenerate

    // Purpose: read mux and hit flag; unmapped addresses read all ones.
    always_comb begin
        bus_hit = sel_req || sel_en;
        if (sel_req)     bus_rdata = req_view;
        else if (sel_en) bus_rdata = en_q;
        else             bus_rdata = '1;
    end

    // Purpose: per-source pending mask.
    always_comb begin
        pending = req_q & en_q[NUM_SRC-1:0];
    end

    // R7: pending never shows a source whose enable bit is clear.
    always_comb begin
        if (rst_n === 1'b1) begin
            a_r7_masked: assert ((pending & ~en_q[NUM_SRC-1:0]) == '0);
        end
    end

    // R2: a request-register read always carries ones in the padding bits.
    a_r2_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
        sel_req |-> (bus_rdata[DATA_W-1:NUM_SRC] == '1));

    // R8: an unmapped address never reports a hit.
    a_r8_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_req && !sel_en) |-> (!bus_hit && bus_rdata == '1));
endmodule

// File: tb/irq_flag_enable_tb.sv
// Scoreboard bench: the driver task updates a reference model and pushes
// expected read items. A monitor pops and compares them at the falling edge.
module irq_flag_enable_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_hit;
    logic        src_frame, src_stat, src_timer, src_serial, src_joypad;
    logic [4:0]  pending;

    always #4 clk = ~clk; // 125 MHz

    irq_flag_enable u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_hit    (bus_hit),
        .src_frame  (src_frame),
        .src_stat   (src_stat),
        .src_timer  (src_timer),
        .src_serial (src_serial),
        .src_joypad (src_joypad),
        .pending    (pending)
    );

    typedef struct {
        logic [7:0] rdata;
        logic       hit;
        logic [4:0] pend;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic chk_now = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference model state.
    logic [4:0] m_req;
    logic [7:0] m_en;

    // Monitor: compare the pending expected item at the falling edge.
    always @(negedge clk) begin
        if (chk_now && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.rdata || bus_hit !== e.hit || pending !== e.pend) begin
                errors++;
                $display("FAIL %s: rdata=%h hit=%b pend=%b expected rdata=%h hit=%b pend=%b",
                         e.tag, bus_rdata, bus_hit, pending, e.rdata, e.hit, e.pend);
            end
        end
    end

    // Driver: one bus cycle, driven 1 ns after the rising edge.
    task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic [4:0] s, input bit chk, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        bus_addr = a; bus_wr = w; bus_wdata = d;
        {src_joypad, src_serial, src_timer, src_stat, src_frame} = s;
        chk_now = chk;
        if (chk) begin
            e.hit   = (a == 16'hFF0F) || (a == 16'hFFFF);
            e.rdata = (a == 16'hFF0F) ? {3'b111, m_req} :
                      (a == 16'hFFFF) ? m_en : 8'hFF;
            e.pend  = m_req & m_en[4:0];
            e.tag   = tag;
            exp_q.push_back(e);
        end
        // Model update that takes effect at the coming edge.
        if (w && a == 16'hFF0F) m_req = d[4:0];
        if (w && a == 16'hFFFF) m_en  = d;
        m_req = m_req | s;
    endtask

    task automatic idle_read(input logic [15:0] a, input string tag);
        step(a, 1'b0, 8'h00, 5'b0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 16'h0000; bus_wr = 1'b0; bus_wdata = 8'h00;
        {src_joypad, src_serial, src_timer, src_stat, src_frame} = 5'b0;
        m_req = 5'h1F; m_en = 8'hFF;
        // Source pulses during reset must not survive it.
        step(16'hFF0F, 1'b1, 8'hFF, 5'h1F, 1'b0, "reset");
        step(16'hFFFF, 1'b1, 8'hFF, 5'h1F, 1'b0, "reset");
        m_req = 5'h00; m_en = 8'h00;
        @(posedge clk); #1; rst_n = 1'b1;
        bus_wr = 1'b0; {src_joypad, src_serial, src_timer, src_stat, src_frame} = 5'b0;

        // R1: reset values.
        idle_read(16'hFF0F, "R1 request after reset");
        idle_read(16'hFFFF, "R1 enable after reset");

        // R4: enable register full width.
        step(16'hFFFF, 1'b1, 8'hA5, 5'b0, 1'b0, "");
        idle_read(16'hFFFF, "R4 enable A5");
        step(16'hFFFF, 1'b1, 8'hFF, 5'b0, 1'b0, "");
        idle_read(16'hFFFF, "R4 enable FF");

        // R3 / R2: request write keeps five bits, reads pad with ones.
        step(16'hFF0F, 1'b1, 8'hFF, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R3 request write FF");
        step(16'hFF0F, 1'b1, 8'h00, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R3 request cleared");
        step(16'hFF0F, 1'b1, 8'h35, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R2 request 35 reads F5");
        step(16'hFF0F, 1'b1, 8'h00, 5'b0, 1'b0, "");

        // R5: each source sets its own bit and stays set.
        for (int i = 0; i < 5; i++) begin
            step(16'h0000, 1'b0, 8'h00, 5'(1 << i), 1'b0, "");
            idle_read(16'hFF0F, "R5 source bit set");
        end
        idle_read(16'hFF0F, "R5 bits sticky");
        step(16'hFF0F, 1'b1, 8'h00, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R3 clear by writing zero");

        // R6: set pulse beats a same-cycle write.
        step(16'hFF0F, 1'b1, 8'h00, 5'b00100, 1'b0, "");
        idle_read(16'hFF0F, "R6 timer beats write of zero");
        step(16'hFF0F, 1'b1, 8'h01, 5'b10000, 1'b0, "");
        idle_read(16'hFF0F, "R6 joypad with write 01");
        step(16'hFF0F, 1'b1, 8'h1A, 5'b00001, 1'b0, "");
        idle_read(16'hFF0F, "R6 frame with write 1A");

        // R7: pending mask, combinational.
        step(16'hFFFF, 1'b1, 8'hE5, 5'b0, 1'b0, "");
        idle_read(16'hFFFF, "R7 pending with enable E5");
        step(16'hFF0F, 1'b1, 8'h1F, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R7 pending all requests");
        step(16'hFFFF, 1'b1, 8'hE0, 5'b0, 1'b0, "");
        idle_read(16'hFF0F, "R7 upper enable bits do not pend");

        // R8: other addresses neither written nor claimed.
        step(16'hFFFF, 1'b1, 8'h3C, 5'b0, 1'b0, "");
        step(16'hFF0F, 1'b1, 8'h09, 5'b0, 1'b0, "");
        step(16'hFF0E, 1'b1, 8'hFF, 5'b0, 1'b1, "R8 write 0xFF0E read");
        step(16'hFFFE, 1'b1, 8'h00, 5'b0, 1'b1, "R8 write 0xFFFE read");
        idle_read(16'hFF0F, "R8 request unchanged");
        idle_read(16'hFFFF, "R8 enable unchanged");
        idle_read(16'hFF10, "R8 unmapped read");

        step(16'h0000, 1'b0, 8'h00, 5'b0, 1'b0, "");
        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule